// File: doc/BRIEF.md
# Signed-to-Unsigned Saturating Narrowing Unit

This unit takes a packed vector of signed two's-complement integers and converts each lane to an unsigned integer of half the width. A lane that is negative becomes zero. A lane that is too large for the narrow range becomes all ones. Every other lane keeps its low bits.

A 2-bit size code selects the narrow element width: 8, 16 or 32 bits. In vector mode the unit produces 64 bits of narrow lanes from the full 128-bit source. That 64-bit result is placed in one half of the destination:
- In the low half, the high half is zeroed.
- In the high half, the low half is taken from the previous destination value that is supplied on an input.

In scalar mode the unit narrows only the lowest source element.

Results are registered and appear one clock after a valid strobe. A per-operation saturation flag and an illegal-size flag accompany each result. A sticky saturation bit is kept by a two-state machine:
- `STK_CLEAR` moves to `STK_SET` on the transition **SET**, which is a legal valid operation with any clamped lane.
- `STK_SET` returns to `STK_CLEAR` on the transition **CLEAR**, which is `sat_clear` high with no SET in the same cycle.
- Both states hold otherwise.

Top module: `sat_narrow_unit`

## Requirements
- R1: The narrow element width is 8 << `lane_size` (8, 16, 32) and each source element is twice that. In vector mode, 64/width lanes are processed, and lane i is read from source bits [i·2w +: 2w] and written to result bits [i·w +: w].
- R2: Each active lane is clamped as a signed value. Negative gives 0. A value above 2^w−1 gives all ones. Any other value gives its low w bits.
- R3: `lane_size` = 3 is illegal. The next cycle shows `bad_size`=1 and `op_sat`=0, and `dst_out` and `sticky_sat` are unchanged.
- R4: With `hi_half`=0 in vector mode, the result goes to `dst_out`[63:0] and `dst_out`[127:64] is zero.
- R5: With `hi_half`=1 in vector mode, the result goes to `dst_out`[127:64] and `dst_out`[63:0] equals `prev_dst`[63:0].
- R6: With `scalar_sel`=1, only the lowest source element (2w bits) is narrowed. It is placed in `dst_out`[w-1:0], all higher bits are zero, and `hi_half` has no effect.
- R7: `op_sat` is the OR of the clamp indications of the active lanes only. In scalar mode that is lane 0 alone.
- R8: `sticky_sat` becomes 1 after any legal operation with `op_sat`=1. Only `sat_clear` lowers it, and a SET in the same cycle wins over `sat_clear`.
- R9: Outputs update on the clock edge that samples `in_valid`=1. Without `in_valid`, `dst_out`, `op_sat` and `bad_size` hold.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_vec | input | 128 | Signed wide source lanes |
| prev_dst | input | 128 | Previous destination value |
| lane_size | input | 2 | Narrow width code (3 illegal) |
| hi_half | input | 1 | Write the upper destination half |
| scalar_sel | input | 1 | Narrow a single element |
| sat_clear | input | 1 | Clear the sticky saturation bit |
| dst_out | output | 128 | Registered destination value |
| op_sat | output | 1 | Last operation saturated |
| bad_size | output | 1 | Last operation used an illegal size |
| sticky_sat | output | 1 | Cumulative saturation bit |

## Verification
The sticky bit can receive a SET from a saturating operation and a CLEAR from `sat_clear` in the same cycle. The bench provokes this by driving a clamping operation with `sat_clear` high. It expects `sticky_sat` to stay 1 afterwards. It then drives `sat_clear` alone and expects the bit to drop to 0. An illegal-size operation combined with `sat_clear` checks that CLEAR still takes effect when no SET is possible.

// File: rtl/sat_narrow_pkg.sv
package sat_narrow_pkg;
    localparam int NUM_SIZES = 3;
    localparam logic [1:0] SIZE_ILLEGAL = 2'b11;

    typedef enum logic {
        STK_CLEAR = 1'b0,
        STK_SET   = 1'b1
    } sticky_state_t;
endpackage

// File: rtl/lane_clamp.sv
module lane_clamp #(
    parameter int OUT_W = 8
) (
    input  logic [2*OUT_W-1:0] wide_in,
    output logic [OUT_W-1:0]   narrow_out,
    output logic               clamped
);
    logic is_neg;
    logic too_big;

    always_comb begin
        is_neg  = wide_in[2*OUT_W-1];
        too_big = |wide_in[2*OUT_W-1:OUT_W];
        if (is_neg) begin
            narrow_out = '0;
            clamped    = 1'b1;
        end else if (too_big) begin
            narrow_out = '1;
            clamped    = 1'b1;
        end else begin
            narrow_out = wide_in[OUT_W-1:0];
            clamped    = 1'b0;
        end
    end
endmodule

// File: rtl/narrow_bank.sv
module narrow_bank #(
    parameter int VEC_W  = 128,
    parameter int ELEM_W = 8
) (
    input  logic [VEC_W-1:0]   src,
    output logic [VEC_W/2-1:0] res,
    output logic               sat_any,
    output logic               sat_lane0
);
    localparam int HALF_W = VEC_W / 2;
    localparam int LANES  = HALF_W / ELEM_W;

    logic [LANES-1:0] lane_sat;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_clamp #(.OUT_W(ELEM_W)) u_clamp (
            .wide_in   (src[l*2*ELEM_W +: 2*ELEM_W]),
            .narrow_out(res[l*ELEM_W +: ELEM_W]),
            .clamped   (lane_sat[l])
        );
    end

    assign sat_any   = |lane_sat;
    assign sat_lane0 = lane_sat[0];
endmodule

// File: rtl/sat_narrow_unit.sv
module sat_narrow_unit
    import sat_narrow_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] src_vec,
    input  logic [VEC_W-1:0] prev_dst,
    input  logic [1:0]       lane_size,
    input  logic             hi_half,
    input  logic             scalar_sel,
    input  logic             sat_clear,
    output logic [VEC_W-1:0] dst_out,
    output logic             op_sat,
    output logic             bad_size,
    output logic             sticky_sat
);
    localparam int HALF_W = VEC_W / 2;

    logic [HALF_W-1:0]    bank_res [NUM_SIZES];
    logic [NUM_SIZES-1:0] bank_sat_any;
    logic [NUM_SIZES-1:0] bank_sat_l0;

    for (genvar g = 0; g < NUM_SIZES; g++) begin : g_bank
        narrow_bank #(.VEC_W(VEC_W), .ELEM_W(8 << g)) u_bank (
            .src      (src_vec),
            .res      (bank_res[g]),
            .sat_any  (bank_sat_any[g]),
            .sat_lane0(bank_sat_l0[g])
        );
    end

    logic             legal;
    logic [VEC_W-1:0] nxt_dst;
    logic             nxt_sat;
    logic [HALF_W-1:0] scalar_res;
    logic             set_evt;

    assign legal = (lane_size != SIZE_ILLEGAL);

    always_comb begin
        scalar_res = '0;
        nxt_sat    = 1'b0;
        nxt_dst    = dst_out;
        unique case (lane_size)
            2'd0: begin
                scalar_res[7:0] = bank_res[0][7:0];
                nxt_sat = scalar_sel ? bank_sat_l0[0] : bank_sat_any[0];
            end
            2'd1: begin
                scalar_res[15:0] = bank_res[1][15:0];
                nxt_sat = scalar_sel ? bank_sat_l0[1] : bank_sat_any[1];
            end
            2'd2: begin
                scalar_res[31:0] = bank_res[2][31:0];
                nxt_sat = scalar_sel ? bank_sat_l0[2] : bank_sat_any[2];
            end
            default: begin
                nxt_sat = 1'b0;
            end
        endcase
        if (legal) begin
            if (scalar_sel) begin
                nxt_dst = {{HALF_W{1'b0}}, scalar_res};
            end else if (hi_half) begin
                nxt_dst = {bank_res[lane_size], prev_dst[HALF_W-1:0]};
            end else begin
                nxt_dst = {{HALF_W{1'b0}}, bank_res[lane_size]};
            end
        end
    end

    assign set_evt = in_valid && legal && nxt_sat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dst_out  <= '0;
            op_sat   <= 1'b0;
            bad_size <= 1'b0;
        end else if (in_valid) begin
            dst_out  <= nxt_dst;
            op_sat   <= legal && nxt_sat;
            bad_size <= !legal;
        end
    end

    sticky_state_t stk_state, stk_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stk_state <= STK_CLEAR;
        else        stk_state <= stk_next;
    end

    always_comb begin
        stk_next = stk_state;
        unique case (stk_state)
            STK_CLEAR: if (set_evt) stk_next = STK_SET;
            STK_SET:   if (sat_clear && !set_evt) stk_next = STK_CLEAR;
            default:   stk_next = STK_CLEAR;
        endcase
    end

    assign sticky_sat = (stk_state == STK_SET);

    // R3
    illegal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_size == 2'b11) |=> (bad_size && !op_sat && $stable(dst_out)));

    // R4
    low_half_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_size != 2'b11 && !hi_half) |=> (dst_out[VEC_W-1:HALF_W] == '0));

    // R5
    high_half_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_size != 2'b11 && hi_half && !scalar_sel)
        |=> (dst_out[HALF_W-1:0] == $past(prev_dst[HALF_W-1:0])));

    // R8
    sticky_follows_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_size != 2'b11) |=> (!op_sat || sticky_sat));

    // R8
    sticky_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sticky_sat) |-> $past(sat_clear));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_out) && $stable(op_sat) && $stable(bad_size)));
endmodule

// File: tb/tb_sat_narrow_unit.sv
module tb_sat_narrow_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] src_vec = '0;
    logic [127:0] prev_dst = '0;
    logic [1:0]   lane_size = '0;
    logic         hi_half = 1'b0;
    logic         scalar_sel = 1'b0;
    logic         sat_clear = 1'b0;
    logic [127:0] dst_out;
    logic         op_sat, bad_size, sticky_sat;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    sat_narrow_unit dut (.*);

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(input logic [127:0] src, input logic [127:0] prv,
                                  input int sz, input bit hi, input bit sc,
                                  output logic [127:0] dst, output bit sat);
        int ew = 8 << sz;
        int lanes = sc ? 1 : 64 / ew;
        logic [63:0] res = '0;
        sat = 0;
        for (int e = 0; e < lanes; e++) begin
            logic [63:0] el, val, emask;
            emask = (ew == 32) ? 64'hFFFF_FFFF : ((64'd1 << ew) - 1);
            el = 64'(src >> (e * 2 * ew));
            if (ew < 32) el = el & ((64'd1 << (2 * ew)) - 1);
            if (el[2*ew-1]) begin val = 0; sat = 1; end
            else if ((el >> ew) != 0) begin val = emask; sat = 1; end
            else val = el & emask;
            res = res | (val << (e * ew));
        end
        if (sc || !hi) dst = {64'd0, res};
        else dst = {res, prv[63:0]};
    endfunction

    task automatic run_op(input logic [127:0] src, input logic [127:0] prv, input logic [1:0] sz,
                          input bit hi, input bit sc, input bit clr, input string req);
        logic [127:0] exp_dst;
        bit exp_sat;
        bit old_sticky;
        old_sticky = sticky_sat;
        model(src, prv, sz, hi, sc, exp_dst, exp_sat);
        @(negedge clk);
        src_vec = src; prev_dst = prv; lane_size = sz; hi_half = hi;
        scalar_sel = sc; sat_clear = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b0;
        chk(dst_out == exp_dst, req, dst_out, exp_dst);
        chk(op_sat == exp_sat, {req, " R7 op_sat"}, 128'(op_sat), 128'(exp_sat));
        chk(bad_size == 1'b0, {req, " bad_size"}, 128'(bad_size), 128'd0);
        chk(sticky_sat == (exp_sat | (old_sticky & !clr)), {req, " R8 sticky"},
            128'(sticky_sat), 128'(exp_sat | (old_sticky & !clr)));
    endtask

    task automatic t_reset();
        chk(dst_out == '0 && !op_sat && !bad_size && !sticky_sat, "R10 reset",
            {dst_out[124:0], op_sat, bad_size, sticky_sat}, 128'd0);
    endtask

    task automatic t_clear_alone();
        @(negedge clk);
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
        chk(sticky_sat == 1'b0, "R8 clear alone", 128'(sticky_sat), 128'd0);
    endtask

    task automatic t_illegal(input bit clr);
        logic [127:0] old_dst;
        bit old_sticky;
        old_dst = dst_out;
        old_sticky = sticky_sat;
        @(negedge clk);
        src_vec = {128{1'b1}}; lane_size = 2'b11; hi_half = 1'b0; scalar_sel = 1'b0;
        sat_clear = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b0;
        chk(bad_size == 1'b1, "R3 flag", 128'(bad_size), 128'd1);
        chk(op_sat == 1'b0, "R3 op_sat", 128'(op_sat), 128'd0);
        chk(dst_out == old_dst, "R3 dst unchanged", dst_out, old_dst);
        chk(sticky_sat == (old_sticky & !clr), "R3 sticky", 128'(sticky_sat), 128'(old_sticky & !clr));
    endtask

    task automatic t_idle();
        logic [127:0] old_dst;
        bit o_sat, o_bad;
        old_dst = dst_out; o_sat = op_sat; o_bad = bad_size;
        @(negedge clk);
        src_vec = ~src_vec; lane_size = 2'd0; hi_half = 1'b0;
        repeat (3) @(negedge clk);
        chk(dst_out == old_dst && op_sat == o_sat && bad_size == o_bad, "R9 idle hold",
            dst_out, old_dst);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        // R1 R2 R4: in-range lanes at each width
        run_op(128'h00FF_007F_0001_0000_0012_0034_0056_0078, '1, 2'd0, 0, 0, 0, "R1 R4 b8 pass");
        run_op(128'h0000_FFFF_0000_1234_0000_0001_0000_ABCD, '1, 2'd1, 0, 0, 0, "R1 R4 b16 pass");
        run_op(128'h0000_0000_DEAD_BEEF_0000_0000_0000_0042, '1, 2'd2, 0, 0, 0, "R1 R4 b32 pass");
        // R2: negative and too-large lanes
        run_op(128'h8000_FFFF_0100_7FFF_00FF_0200_FF80_0003, 128'h0, 2'd0, 0, 0, 0, "R2 b8 clamp");
        t_clear_alone();
        run_op(128'h0001_0000_FFFF_FFFF_0000_FFFF_7FFF_0000, 128'h0, 2'd1, 0, 0, 0, "R2 b16 clamp");
        run_op(128'hFFFF_FFFF_FFFF_FFFF_0000_0001_0000_0000, 128'h0, 2'd2, 0, 0, 0, "R2 b32 clamp");
        t_clear_alone();
        // R5: upper half keeps previous low half
        run_op(128'h0011_0022_0033_0044_0055_0066_0077_0088, 128'hAAAA_BBBB_CCCC_DDDD_1234_5678_9ABC_DEF0,
               2'd0, 1, 0, 0, "R5 b8 upper");
        run_op(128'h0000_0000_1_0000_0000_0000_0000_0005, 128'h5555_6666_7777_8888_0F0F_F0F0_1111_2222,
               2'd2, 1, 0, 0, "R5 b32 upper");
        t_clear_alone();
        // R6 R7: scalar, only lane 0 counts, upper lanes saturating ignored
        run_op(128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_0033, '1, 2'd0, 1, 1, 0, "R6 R7 scalar b8");
        run_op(128'h8000_0000_0000_0000_0000_0000_0001_0000, '1, 2'd1, 0, 1, 0, "R6 scalar b16 sat");
        run_op(128'h0, 128'h0, 2'd2, 0, 1, 0, "R6 scalar b32 zero");
        // R8: set and clear in the same cycle, set wins
        run_op(128'h0000_0000_0000_0000_0000_0000_0000_FF00, 128'h0, 2'd0, 0, 0, 1, "R8 set beats clear");
        chk(sticky_sat == 1'b1, "R8 set beats clear hold", 128'(sticky_sat), 128'd1);
        // R3: illegal size, without and with clear
        t_illegal(1'b0);
        t_illegal(1'b1);
        // R9: idle hold
        run_op(128'h0000_0000_0000_0000_0000_0000_1234_5678, 128'h0, 2'd2, 0, 0, 0, "R9 before idle");
        t_idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule